// File: doc/BRIEF.md
# Boolean Condition Register Unit

This block keeps a sixteen-entry file of single-bit condition flags for a small processor core and carries out the operations that work on those flags. It combines two flags with a bit-logic function and stores the result in a third. It folds an aligned group of four or eight flags into one ANY or ALL result. It also tests a single flag, either to qualify a conditional register move or to decide a conditional branch.

The core's decoder supplies an operation class, a function code and three 4-bit register fields (r, s, t). For branches it also supplies an 8-bit signed immediate. The whole flag file can be written and read as one special register. The unit drives a move-enable flag for the integer datapath, a branch-taken flag with its byte offset, and an illegal-operation flag. The integer register file and the program counter stay outside the unit.

Top module: `bool_cond_unit`

## Requirements
- R1: A synchronous active-high reset clears all 16 flags to zero, and the flags read as zero after reset.
- R2: A special-register write with selector 4 (`sr_wr`=1, `sr_num`=4) loads the flags from the low 16 bits of the write data on the next rising edge. `sr_rdata` returns the flags zero-extended when `sr_num` is 4, and zero for any other selector. A write with any other selector leaves the flags unchanged.
- R3: Bit-logic class (`op_cls`=1) combines flag s (a) with flag t (b) and stores the result in flag r on the next edge, with every other flag unchanged. The `op_fn` codes are: 0 = a AND b, 1 = a AND NOT b, 2 = a OR b, 3 = a OR NOT b, 4 = a XOR b.
- R4: In the bit-logic class, `op_fn` values 5 to 7 raise `illegal` in the same cycle and leave the flags unchanged.
- R5: Reduction class (`op_cls`=2) reads the group of flags starting at index s and stores one result in flag t, with every other flag unchanged. Bit 1 of r selects the group size (1 = eight flags, 0 = four flags). Bit 0 of r selects ALL (1: every flag in the group is set) or ANY (0: at least one flag in the group is set).
- R6: A reduction whose start index s is not a multiple of the group size raises `illegal` in the same cycle and leaves the flags unchanged.
- R7: Move class (`op_cls`=3) drives `mov_en` combinationally. With `op_fn[0]`=0 it is high when flag t is clear. With `op_fn[0]`=1 it is high when flag t is set.
- R8: Branch class (`op_cls`=4) drives `br_taken` combinationally. With `op_fn[0]`=0 it is high when flag s is clear. With `op_fn[0]`=1 it is high when flag s is set. `br_offset` always equals 4 plus the sign-extended `br_imm`.
- R9: When a selector-4 special-register write and a flag-modifying operation arrive in the same cycle, the special-register write decides the new flag value.
- R10: With `op_valid` low, or with a class other than 1 to 4 (class 0 is no operation), `mov_en`, `br_taken` and `illegal` stay low. Such an operation leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_cls | input | 3 | Operation class: 0 none, 1 bit logic, 2 reduction, 3 move, 4 branch |
| op_fn | input | 3 | Function code within the class |
| f_r | input | 4 | r field |
| f_s | input | 4 | s field |
| f_t | input | 4 | t field |
| br_imm | input | 8 | Signed branch immediate |
| sr_wr | input | 1 | Special-register write strobe |
| sr_num | input | 8 | Special-register selector |
| sr_wdata | input | 32 | Special-register write data |
| sr_rdata | output | 32 | Special-register read data |
| cond_q | output | 16 | Current flag values |
| mov_en | output | 1 | Conditional move enable |
| br_taken | output | 1 | Branch decision |
| br_offset | output | 32 | Branch target offset |
| illegal | output | 1 | Illegal operation indication |

## Verification
`mov_en`, `br_taken`, `illegal`, `br_offset` and `sr_rdata` are combinational, so their values are due in the same cycle as the stimulus. The bench samples them one nanosecond after it drives the inputs on a falling edge. A flag update appears on `cond_q` one rising edge after the operation, so the bench reads the flag value at the next falling edge, after it has dropped the strobe. A preload written through the special register likewise shows on the flags one edge later, so every vector spends one cycle on the preload before its operation cycle.

// File: rtl/bool_cond_unit.sv
module bool_cond_unit #(
  parameter int NB    = 16,
  parameter int IW    = $clog2(NB),
  parameter int DW    = 32,
  parameter int OFS_W = 32,
  parameter logic [7:0] SR_ID = 8'd4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_cls,
  input  logic [2:0]       op_fn,
  input  logic [IW-1:0]    f_r,
  input  logic [IW-1:0]    f_s,
  input  logic [IW-1:0]    f_t,
  input  logic [7:0]       br_imm,
  input  logic             sr_wr,
  input  logic [7:0]       sr_num,
  input  logic [DW-1:0]    sr_wdata,
  output logic [DW-1:0]    sr_rdata,
  output logic [NB-1:0]    cond_q,
  output logic             mov_en,
  output logic             br_taken,
  output logic [OFS_W-1:0] br_offset,
  output logic             illegal
);
  localparam logic [2:0] CLS_LOG = 3'd1;
  localparam logic [2:0] CLS_RED = 3'd2;
  localparam logic [2:0] CLS_MOV = 3'd3;
  localparam logic [2:0] CLS_BR  = 3'd4;
  localparam int GW = 8;
  localparam int HW = GW / 2;

  logic sr_hit, is_log, is_red, is_mov, is_br;
  logic bit_s, bit_t, log_res, log_ok;
  logic wide, misal, red_res;
  logic [GW-1:0] grp, gx, addend;
  logic [GW:0]   sum;
  logic [NB-1:0] nxt;

  assign sr_hit = sr_wr && (sr_num == SR_ID);
  assign is_log = op_valid && (op_cls == CLS_LOG);
  assign is_red = op_valid && (op_cls == CLS_RED);
  assign is_mov = op_valid && (op_cls == CLS_MOV);
  assign is_br  = op_valid && (op_cls == CLS_BR);

  assign bit_s = cond_q[f_s];
  assign bit_t = cond_q[f_t];

  always_comb begin
    log_ok = 1'b1;
    case (op_fn)
      3'd0:    log_res = bit_s & bit_t;
      3'd1:    log_res = bit_s & ~bit_t;
      3'd2:    log_res = bit_s | bit_t;
      3'd3:    log_res = bit_s | ~bit_t;
      3'd4:    log_res = bit_s ^ bit_t;
      default: begin log_res = 1'b0; log_ok = 1'b0; end
    endcase
  end

  assign wide   = f_r[1];
  assign misal  = wide ? (f_s[2:0] != 3'd0) : (f_s[1:0] != 2'd0);
  assign grp    = GW'(cond_q >> f_s);
  assign gx     = wide ? grp : {{(GW-HW){1'b0}}, grp[HW-1:0]};
  assign addend = f_r[0] ? GW'(1) : (wide ? {GW{1'b1}} : {{(GW-HW){1'b0}}, {HW{1'b1}}});
  assign sum    = {1'b0, gx} + {1'b0, addend};
  assign red_res = wide ? sum[GW] : sum[HW];

  assign illegal  = (is_log && !log_ok) || (is_red && misal);
  assign mov_en   = is_mov && (bit_t == op_fn[0]);
  assign br_taken = is_br && (bit_s == op_fn[0]);
  assign br_offset = OFS_W'(4) + {{(OFS_W-8){br_imm[7]}}, br_imm};
  assign sr_rdata = (sr_num == SR_ID) ? {{(DW-NB){1'b0}}, cond_q} : '0;

  always_comb begin
    nxt = cond_q;
    if (sr_hit)
      nxt = sr_wdata[NB-1:0];
    else if (is_log && log_ok)
      nxt[f_r] = log_res;
    else if (is_red && !misal)
      nxt[f_t] = red_res;
  end

  always_ff @(posedge clk) begin
    if (rst) cond_q <= '0;
    else     cond_q <= nxt;
  end
endmodule

module bool_cond_unit_chk #(
  parameter int NB = 16,
  parameter int DW = 32,
  parameter logic [7:0] SR_ID = 8'd4
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [2:0]    op_cls,
  input logic          sr_wr,
  input logic [7:0]    sr_num,
  input logic [DW-1:0] sr_wdata,
  input logic [DW-1:0] sr_rdata,
  input logic [NB-1:0] cond_q,
  input logic          mov_en,
  input logic          br_taken,
  input logic          illegal
);
  logic hit;
  assign hit = sr_wr && (sr_num == SR_ID);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> cond_q == '0);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    sr_rdata[DW-1:NB] == '0);

  p_single_bit_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_cls == 3'd1 && !hit) |=> $countones(cond_q ^ $past(cond_q)) <= 1);

  p_illegal_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (illegal && !hit) |=> $stable(cond_q));

  p_sr_priority_r9: assert property (@(posedge clk) disable iff (rst)
    hit |=> cond_q == $past(sr_wdata[NB-1:0]));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> !mov_en && !br_taken && !illegal);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !hit) |=> $stable(cond_q));

  p_excl_flags_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mov_en, br_taken, illegal}));
endmodule

bind bool_cond_unit bool_cond_unit_chk #(.NB(NB), .DW(DW), .SR_ID(SR_ID)) i_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_cls(op_cls), .sr_wr(sr_wr),
  .sr_num(sr_num), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .cond_q(cond_q),
  .mov_en(mov_en), .br_taken(br_taken), .illegal(illegal)
);

// File: tb/test_bool_cond_unit.sv
`timescale 1ns/1ps
module test_bool_cond_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [2:0] op_cls = '0, op_fn = '0;
  logic [3:0] f_r = '0, f_s = '0, f_t = '0;
  logic [7:0] br_imm = '0;
  logic sr_wr = 1'b0;
  logic [7:0] sr_num = '0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] sr_rdata, br_offset;
  logic [15:0] cond_q;
  logic mov_en, br_taken, illegal;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  bool_cond_unit i_bool_cond_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_cls(op_cls), .op_fn(op_fn),
    .f_r(f_r), .f_s(f_s), .f_t(f_t), .br_imm(br_imm), .sr_wr(sr_wr),
    .sr_num(sr_num), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .cond_q(cond_q),
    .mov_en(mov_en), .br_taken(br_taken), .br_offset(br_offset), .illegal(illegal)
  );

  // {pre, cls, fn, r, s, t, expected flags, mov, br, ill, tag}
  localparam int NV = 21;
  localparam logic [56:0] VEC [NV] = '{
    {16'h0003, 3'd1, 3'd0, 4'd5,  4'd0,  4'd1, 16'h0023, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 and
    {16'h0003, 3'd1, 3'd1, 4'd5,  4'd0,  4'd1, 16'h0003, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 and-not
    {16'h0004, 3'd1, 3'd2, 4'd0,  4'd2,  4'd3, 16'h0005, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 or
    {16'h0000, 3'd1, 3'd3, 4'd15, 4'd1,  4'd2, 16'h8000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 or-not
    {16'hFFFF, 3'd1, 3'd4, 4'd7,  4'd0,  4'd1, 16'hFF7F, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 xor
    {16'h1234, 3'd1, 3'd5, 4'd0,  4'd2,  4'd4, 16'h1234, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
    {16'h0101, 3'd2, 3'd0, 4'd0,  4'd4,  4'd0, 16'h0100, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 any4 false
    {16'h0100, 3'd2, 3'd0, 4'd0,  4'd8,  4'd1, 16'h0102, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 any4 true
    {16'hF000, 3'd2, 3'd0, 4'd1,  4'd12, 4'd0, 16'hF001, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 all4 true
    {16'h7F04, 3'd2, 3'd0, 4'd3,  4'd8,  4'd2, 16'h7F00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 all8 false
    {16'h00FF, 3'd2, 3'd0, 4'd3,  4'd0,  4'd15,16'h80FF, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 all8 true
    {16'h8000, 3'd2, 3'd0, 4'd2,  4'd8,  4'd3, 16'h8008, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 any8 true
    {16'h00F0, 3'd2, 3'd0, 4'd0,  4'd2,  4'd0, 16'h00F0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 misaligned 4
    {16'h00F0, 3'd2, 3'd0, 4'd2,  4'd4,  4'd0, 16'h00F0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 misaligned 8
    {16'h0000, 3'd3, 3'd0, 4'd0,  4'd0,  4'd3, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 if-false
    {16'h0000, 3'd3, 3'd1, 4'd0,  4'd0,  4'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 if-true no
    {16'h0200, 3'd3, 3'd1, 4'd0,  4'd0,  4'd9, 16'h0200, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 if-true yes
    {16'h0040, 3'd4, 3'd0, 4'd0,  4'd6,  4'd0, 16'h0040, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 bf not taken
    {16'h0040, 3'd4, 3'd1, 4'd0,  4'd6,  4'd0, 16'h0040, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 bt taken
    {16'h0000, 3'd4, 3'd0, 4'd0,  4'd6,  4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 bf taken
    {16'hABCD, 3'd0, 3'd0, 4'd1,  4'd2,  4'd3, 16'hABCD, 1'b0, 1'b0, 1'b0, 4'd10}  // R10 no-op class
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sr_write(input logic [7:0] num, input logic [31:0] d);
    @(negedge clk);
    sr_wr = 1'b1; sr_num = num; sr_wdata = d; op_valid = 1'b0;
    @(negedge clk);
    sr_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    sr_num = 8'd4; #1;
    chk("R1", "flags after reset", 32'(cond_q), 32'h0);
    chk("R1", "readback after reset", sr_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d", v[3:0]);
      sr_write(8'd4, {16'h0, v[56:41]});
      op_valid = 1'b1; op_cls = v[40:38]; op_fn = v[37:35];
      f_r = v[34:31]; f_s = v[30:27]; f_t = v[26:23];
      #1;
      chk(tg, "mov_en", 32'(mov_en), 32'(v[6]));
      chk(tg, "br_taken", 32'(br_taken), 32'(v[5]));
      chk(tg, "illegal", 32'(illegal), 32'(v[4]));
      @(negedge clk);
      op_valid = 1'b0; op_cls = 3'd0;
      #1;
      chk(tg, "flags", 32'(cond_q), 32'(v[22:7]));
    end

    // R2 masking and readback
    sr_write(8'd4, 32'hDEADBEEF);
    #1;
    chk("R2", "masked flags", 32'(cond_q), 32'h0000BEEF);
    chk("R2", "readback sel 4", sr_rdata, 32'h0000BEEF);
    sr_num = 8'd5; #1;
    chk("R2", "readback other sel", sr_rdata, 32'h0);
    sr_write(8'd5, 32'h00001234);
    sr_num = 8'd4; #1;
    chk("R2", "write other sel ignored", 32'(cond_q), 32'h0000BEEF);

    // R8 offset
    br_imm = 8'hF0; #1;
    chk("R8", "offset negative", br_offset, 32'hFFFFFFF4);
    br_imm = 8'h7F; #1;
    chk("R8", "offset positive", br_offset, 32'h00000083);

    // R9 priority: op would set flag 15, special write wins
    sr_write(8'd4, 32'h0);
    @(negedge clk);
    op_valid = 1'b1; op_cls = 3'd1; op_fn = 3'd3; f_r = 4'd15; f_s = 4'd0; f_t = 4'd1;
    sr_wr = 1'b1; sr_num = 8'd4; sr_wdata = 32'h00001111;
    @(negedge clk);
    op_valid = 1'b0; sr_wr = 1'b0; #1;
    chk("R9", "write beats op", 32'(cond_q), 32'h00001111);

    // R10 valid low: no update, outputs quiet
    op_cls = 3'd1; op_fn = 3'd3; f_r = 4'd15; #1;
    chk("R10", "illegal quiet", 32'(illegal), 32'h0);
    op_cls = 3'd4; op_fn = 3'd0; f_s = 4'd1; #1;
    chk("R10", "branch quiet", 32'(br_taken), 32'h0);
    op_cls = 3'd3; op_fn = 3'd0; f_t = 4'd1; #1;
    chk("R10", "move quiet", 32'(mov_en), 32'h0);
    op_cls = 3'd1; op_fn = 3'd3;
    @(negedge clk); #1;
    chk("R10", "flags held", 32'(cond_q), 32'h00001111);

    // R1 reset from nonzero
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; #1;
    chk("R1", "reset clears", 32'(cond_q), 32'h0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule